// File: doc/BRIEF.md
# UDP Echo Header Swapper

This block sits on a 32-bit packet stream in which each packet starts at its IPv4 header and is framed by start and end markers on the first and last words. When the select input is high on a packet's first word and the packet is a plain IPv4 UDP packet, the block turns the packet around so that it returns to where it came from. It exchanges the source and destination address words, and it exchanges the two 16-bit port fields. All other words leave unchanged, including the header checksum, the length fields and the payload. Packets that are not selected, that do not carry UDP, or whose header has options pass through untouched.

The same path serves program packets that are echoed back to their sender and finished data packets that are returned after processing. The caller drives the select input with the packet's first word. Words enter and leave over valid/ready handshakes. The block holds at most two words, and a continuous stream flows through it at one word per cycle.

The word layout is fixed. Word 0 carries version and header length in bits 31:24, and the block requires 0x45 there. Word 2 carries the protocol in bits 23:16, and UDP is 17. Word 3 is the source address, word 4 is the destination address, and word 5 holds the source port in bits 31:16 and the destination port in bits 15:0.

Top module: `udp_echo_swapper`

## Requirements
- R1: In a swapped packet (select high on the start word, word 0 bits 31:24 equal to 0x45, word 2 bits 23:16 equal to 17), word 4 is output in position 3 and word 3 is output in position 4.
- R2: In a swapped packet, word 5 is output with bits 31:16 and bits 15:0 exchanged.
- R3: In a swapped packet, words 0 to 2 and all words from 6 onward are output unchanged.
- R4: A packet whose word 2 bits 23:16 are not 17 is output unchanged, even when selected.
- R5: A packet whose select input is low on its start word is output unchanged.
- R6: A packet whose word 0 bits 31:24 are not 0x45 is output unchanged, even when selected.
- R7: The select input is sampled only with a packet's start word. Changing it on later words of the same packet has no effect on that packet.
- R8: The output carries exactly the input words, in packet order. The start and end markers sit on the first and last output word of each packet, and every packet starts after the previous one has ended.
- R9: While the output is valid and not ready, the output valid, data and markers hold steady. No word is lost or repeated.
- R10: The block holds no more than two words. It accepts input whenever its output is not valid.
- R11: During and right after reset, the output is not valid and the input is ready.
- R12: A selected UDP packet that ends on its source-address word is output unchanged, without waiting for a further word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| echoSel | input | 1 | Return request, sampled with the start word |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Block can take an input word |
| inData | input | 32 | Input word |
| inSop | input | 1 | Input word is first of packet |
| inEop | input | 1 | Input word is last of packet |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Receiver takes the output word |
| outData | output | 32 | Output word |
| outSop | output | 1 | Output word is first of packet |
| outEop | output | 1 | Output word is last of packet |

## Verification
The bench targets the exchange of the address words under backpressure and input gaps. A design that let the source word leave before the destination word arrived would emit the addresses in their original order. A design that moved the markers with the exchanged data would put an end marker in the middle of the header. Packets ending on the source word check that the block does not stall waiting for a partner word that never comes. Toggling the select input in the middle of a packet, and sending wrong protocol or header bytes, catch a classifier that samples at the wrong time or checks the wrong field.

// File: rtl/udp_swap_pkg.sv
package udp_swap_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load0;     // stage 0 takes the input word
    logic shift;     // stage 1 takes its word this cycle
    logic exch;      // incoming word goes to stage 1, stage 0 keeps its data
    logic portSwap;  // incoming word has its halves exchanged
  } swapStrobe_t;
endpackage

// File: rtl/udp_swap_ctrl.sv
module udp_swap_ctrl
  import udp_swap_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int PROTO_UDP = 17,
  parameter int VER_IHL   = 8'h45,
  parameter int SRC_IDX   = 3,
  parameter int PORT_IDX  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        echoSel,
  input  logic        inValid,
  input  logic        inSop,
  input  logic        inEop,
  input  logic [7:0]  verIhlByte,
  input  logic [7:0]  protoByte,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output swapStrobe_t strobe
);
  localparam logic [IDX_W-1:0] IDX_MAX   = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_PROTO = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_SRC   = IDX_W'(SRC_IDX);
  localparam logic [IDX_W-1:0] IDX_PORT  = IDX_W'(PORT_IDX);

  logic [IDX_W-1:0] wordIdx, curIdx;
  logic candSwap, pktSwap;
  logic valid0, valid1, hold0;
  logic adv1, inAcc, inIsSrc, shift;

  always_comb begin
    curIdx  = inSop ? '0 : wordIdx;
    adv1    = !valid1 || outReady;
    inReady = !valid0 || adv1;
    inAcc   = inValid && inReady;
    inIsSrc = (curIdx == IDX_SRC) && pktSwap && !inEop;
    // a held source word leaves only together with its partner
    shift   = valid0 && adv1 && (!hold0 || inValid);
    strobe.load0    = inAcc;
    strobe.shift    = shift;
    strobe.exch     = shift && hold0;
    strobe.portSwap = (curIdx == IDX_PORT) && pktSwap;
    outValid = valid1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      candSwap <= 1'b0;
      pktSwap  <= 1'b0;
    end else if (inAcc) begin
      if (inEop) wordIdx <= '0;
      else if (curIdx != IDX_MAX) wordIdx <= curIdx + 1'b1;
      if (curIdx == '0) begin
        candSwap <= echoSel && (verIhlByte == 8'(VER_IHL));
        pktSwap  <= 1'b0;
      end
      if (curIdx == IDX_PROTO) pktSwap <= candSwap && (protoByte == 8'(PROTO_UDP));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid0 <= 1'b0;
      valid1 <= 1'b0;
      hold0  <= 1'b0;
    end else begin
      if (inAcc) begin
        valid0 <= 1'b1;
        hold0  <= inIsSrc;
      end else if (shift) begin
        valid0 <= 1'b0;
        hold0  <= 1'b0;
      end
      if (shift) valid1 <= 1'b1;
      else if (outReady) valid1 <= 1'b0;
    end
  end
endmodule

// File: rtl/udp_swap_dp.sv
module udp_swap_dp
  import udp_swap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] inWord, data0, data1;
  logic sop0, eop0, sop1, eop1;

  assign inWord = strobe.portSwap ? {inData[HALF-1:0], inData[DATA_W-1:HALF]} : inData;

  // markers always move in position; only data is exchanged
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      data0 <= '0; sop0 <= 1'b0; eop0 <= 1'b0;
      data1 <= '0; sop1 <= 1'b0; eop1 <= 1'b0;
    end else begin
      if (strobe.load0) begin
        sop0 <= inSop;
        eop0 <= inEop;
        if (!strobe.exch) data0 <= inWord;
      end
      if (strobe.shift) begin
        sop1  <= sop0;
        eop1  <= eop0;
        data1 <= strobe.exch ? inWord : data0;
      end
    end
  end

  assign outData = data1;
  assign outSop  = sop1;
  assign outEop  = eop1;
endmodule

// File: rtl/udp_echo_swapper.sv
module udp_echo_swapper
  import udp_swap_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  parameter int PROTO_UDP = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              echoSel,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop
);
  localparam int PROTO_MSB = DATA_W - 9;

  swapStrobe_t strobe;

  udp_swap_ctrl #(.IDX_W(IDX_W), .PROTO_UDP(PROTO_UDP)) u_ctrl (
    .clk(clk), .rstN(rstN), .echoSel(echoSel),
    .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .verIhlByte(inData[DATA_W-1 -: 8]), .protoByte(inData[PROTO_MSB -: 8]),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  udp_swap_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inData(inData), .inSop(inSop), .inEop(inEop),
    .outData(outData), .outSop(outSop), .outEop(outEop)
  );
endmodule

// File: rtl/udp_echo_swapper_chk.sv
module udp_echo_swapper_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outSop,
  input logic              outEop
);
  logic [2:0] occ;
  logic outInPkt;
  logic inAcc, outAcc;

  assign inAcc  = inValid && inReady;
  assign outAcc = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ      <= '0;
      outInPkt <= 1'b0;
    end else begin
      occ <= occ + 3'(inAcc) - 3'(outAcc);
      if (outAcc) outInPkt <= !outEop;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop) && $stable(outEop)); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady); // R10
  AST_MAX_OCCUPANCY: assert property (@(posedge clk) disable iff (!rstN)
    occ <= 3'd2); // R10
  AST_SOP_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSop |-> !outInPkt); // R8
  AST_MID_NO_SOP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outInPkt |-> !outSop); // R8
endmodule

bind udp_echo_swapper udp_echo_swapper_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outSop(outSop), .outEop(outEop)
);

// File: tb/udp_echo_swapper_tb.sv
`timescale 1ns/1ps
module udp_echo_swapper_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic echoSel = 1'b0, inValid = 1'b0, inSop = 1'b0, inEop = 1'b0, outReady = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, outValid, outSop, outEop;
  logic [31:0] outData;

  int testsRun = 0, testsFailed = 0, cycles = 0;
  bit randReady = 1'b0, randGap = 1'b0, done = 1'b0;
  string pktTag = "";

  logic [33:0] expQ[$];
  string tagQ[$];

  // model state
  int mIdx = 0;
  bit mCand, mSwap, hasStash;
  logic [31:0] stash;
  string mReason = "R5";
  bit prevStall = 1'b0;
  logic [33:0] prevOut;

  always #2 clk = ~clk;

  udp_echo_swapper u_dut (
    .clk(clk), .rstN(rstN), .echoSel(echoSel), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSop(inSop), .inEop(inEop), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSop(outSop), .outEop(outEop)
  );

  task automatic check(bit ok, string tag, string what, logic [33:0] act, logic [33:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic pushExp(logic [31:0] d, bit s, bit e, string t);
    expQ.push_back({s, e, d});
    tagQ.push_back(t);
  endtask

  task automatic modelIn(logic [31:0] d, bit s, bit e, bit sel);
    string t;
    if (s) mIdx = 0;
    if (mIdx == 0) begin
      mCand = sel && (d[31:24] == 8'h45);
      mSwap = 1'b0;
      mReason = !sel ? "R5" : (d[31:24] != 8'h45) ? "R6" : "R4";
    end
    if (mIdx == 2) mSwap = mCand && (d[23:16] == 8'd17);
    if (pktTag != "") t = pktTag;
    else if (mSwap) t = (mIdx == 3 || mIdx == 4) ? "R1" : (mIdx == 5) ? "R2" : "R3";
    else t = (mIdx < 3) ? "R3" : mReason;
    if (mSwap && mIdx == 3 && !e) begin
      stash = d; hasStash = 1'b1;
    end else if (hasStash) begin
      pushExp(d, 1'b0, 1'b0, t);
      pushExp(stash, 1'b0, e, t);
      hasStash = 1'b0;
    end else if (mSwap && mIdx == 5) pushExp({d[15:0], d[31:16]}, s, e, t);
    else pushExp(d, s, e, t);
    mIdx = e ? 0 : mIdx + 1;
  endtask

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      if (prevStall)
        check(outValid && {outSop, outEop, outData} == prevOut, "R9", "stall hold",
              {outSop, outEop, outData}, prevOut);
      if (!outValid) check(inReady, "R10", "ready when empty", 34'(inReady), 34'd1);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R8", "extra word", {outSop, outEop, outData}, '0);
        else begin
          logic [33:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outData == e[31:0], t, "data", 34'(outData), 34'(e[31:0]));
          check({outSop, outEop} == e[33:32], "R8", "markers", 34'({outSop, outEop}), 34'(e[33:32]));
        end
      end
      prevStall = outValid && !outReady;
      prevOut = {outSop, outEop, outData};
      if (inValid && inReady) modelIn(inData, inSop, inEop, echoSel);
    end
  end

  // output ready pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      outReady = randReady ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic sendWord(logic [31:0] d, bit s, bit e, bit sel);
    inValid = 1'b1; inData = d; inSop = s; inEop = e; echoSel = sel;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0;
    if (randGap) repeat ($urandom % 3) begin @(posedge clk); #1; end
  endtask

  // flip: 0 none, 1 select inverted after the start word
  task automatic sendPkt(int len, bit sel, logic [7:0] verIhl, logic [7:0] proto, bit flip, string tag, int k);
    pktTag = tag;
    for (int i = 0; i < len; i++) begin
      logic [31:0] w;
      case (i)
        0: w = {verIhl, 8'h00, 16'(len * 4)};
        1: w = {16'(k), 16'h4000};
        2: w = {8'h40, proto, 16'hBEEF};
        3: w = 32'h0A000001 + 32'(k);
        4: w = 32'hC0A80002 + 32'(k << 8);
        5: w = {16'(1000 + k), 16'(5000 + k)};
        default: w = 32'h5A000000 + 32'(k * 64 + i);
      endcase
      sendWord(w, i == 0, i == len - 1, (i == 0) ? sel : (flip ? !sel : sel));
    end
  endtask

  task automatic runSet(int base);
    sendPkt(9, 1, 8'h45, 8'd17, 0, "", base + 0);   // R1 R2 R3
    sendPkt(8, 0, 8'h45, 8'd17, 0, "", base + 1);   // R5
    sendPkt(8, 1, 8'h45, 8'd6, 0, "", base + 2);    // R4
    sendPkt(8, 1, 8'h46, 8'd17, 0, "", base + 3);   // R6
    sendPkt(8, 1, 8'h45, 8'd17, 1, "R7", base + 4); // R7 flip to low mid packet
    sendPkt(8, 0, 8'h45, 8'd17, 1, "R7", base + 5); // R7 flip to high mid packet
    sendPkt(4, 1, 8'h45, 8'd17, 0, "R12", base + 6); // R12 ends on source word
    sendPkt(5, 1, 8'h45, 8'd17, 0, "", base + 7);   // ends on destination word
    sendPkt(6, 1, 8'h45, 8'd17, 0, "", base + 8);   // ends on port word
    sendPkt(1, 1, 8'h45, 8'd17, 0, "R8", base + 9); // single word
    sendPkt(12, 1, 8'h45, 8'd17, 0, "", base + 10);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid && inReady, "R11", "in reset", {outValid, inReady}, 34'b01);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && inReady, "R11", "after reset", {outValid, inReady}, 34'b01);
    @(posedge clk); #1;
    runSet(0);
    randGap = 1'b1;
    runSet(20);
    randReady = 1'b1; randGap = 1'b0;
    runSet(40);
    randGap = 1'b1;
    for (int r = 0; r < 4; r++) runSet(60 + r * 20);
    begin
      int wait_c = 0;
      while (expQ.size() != 0 && wait_c < 1000) begin @(posedge clk); wait_c++; end
    end
    @(negedge clk);
    check(expQ.size() == 0, "R8", "all words out", 34'(expQ.size()), 34'd0);
    done = 1'b1;
    finishRun();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      check(1'b0, "R9", "watchdog expired", 34'(cycles), '0);
      finishRun();
    end
  end
endmodule